// File: doc/BRIEF.md
# Separable 3x3 Gaussian Smoothing Engine

This block smooths a grayscale frame held in its own memory using a 3x3 Gaussian kernel that has been split into two one-dimensional passes. The frame is first loaded through a write port. A start pulse then sweeps the frame twice. The first sweep filters each row with the taps [1 2 1] and writes the unshifted result to an intermediate buffer. The second sweep applies the same taps down each column of that buffer, divides by 16 and stores the smoothed pixel. When both sweeps are finished, a completion flag rises, and the result can then be read back through a separate read port.

A single shift-and-add unit serves both sweeps and produces one value per clock. Each output pixel therefore costs 2N multiplies (done as shifts) and 2N-2 adds, where N is the tap count, instead of N² and N²-1. Taps that fall outside the frame take the value of the nearest edge pixel. The frame size is set by parameters: the target frame is 256x256, and the defaults are smaller so the memories stay modest.

Top module: `gauss_sep_filter`

## Requirements
- R1: Pixels are 8-bit unsigned and are stored row-major, so pixel (row r, column c) has address r*IMG_W + c. When `ld_we` is high and the block is not busy, `ld_data` is written to `ld_addr`.
- R2: The row sweep produces the unshifted value P(r,c-1) + 2*P(r,c) + P(r,c+1), which has a range of 0..1020.
- R3: The column sweep produces (M(r-1,c) + 2*M(r,c) + M(r+1,c)) >> 4 from the row-sweep values M. The shift truncates, and the output lies in 0..255. A uniform frame of value v returns v.
- R4: A tap outside the frame uses the nearest edge pixel, on the left and right borders and on the top and bottom borders.
- R5: `done` rises exactly 2*IMG_W*IMG_H clock edges after the edge that samples `start`.
- R6: `done` stays high until the next start. A start while idle or done begins a new frame and clears `done` on the edge that samples it.
- R7: A start that arrives during a sweep is ignored, and the completion timing is unchanged.
- R8: A load write that arrives during a sweep is ignored, and the result matches the frame that was loaded before start.
- R9: Reset clears `done` and returns the block to idle, where it does not complete until a new start arrives.
- R10: `rd_data` shows the smoothed pixel at `rd_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin filtering the stored frame |
| ld_we | input | 1 | Input-frame write enable |
| ld_addr | input | AW | Input-frame write address (row-major) |
| ld_data | input | 8 | Pixel to store |
| rd_addr | input | AW | Result read address |
| rd_data | output | 8 | Smoothed pixel at rd_addr |
| done | output | 1 | Frame complete, held until next start |

## Verification
The bench builds the engine with a 16x8 frame. At that size a run takes 256 cycles, so every output pixel of several frames can be compared against an arithmetic model: random, saturated, zero, an impulse and a step. A large share of the pixels in a frame this size touch a border or a corner, so edge replication is checked in every direction many times. The small size also leaves room to inject a start and a load in the middle of a sweep, and a reset in the middle of a run.

// File: rtl/gauss_pkg.sv
package gauss_pkg;
    localparam int PIX_W = 8;
    localparam int MID_W = PIX_W + 2;
    localparam int SUM_W = PIX_W + 4;
    localparam int SHIFT = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HPASS = 2'd1,
        ST_VPASS = 2'd2,
        ST_DONE  = 2'd3
    } flt_state_e;

    typedef struct packed {
        logic [MID_W-1:0] prev;
        logic [MID_W-1:0] cur;
        logic [MID_W-1:0] next;
    } tap_win_t;

    function automatic logic [SUM_W-1:0] tap121(input tap_win_t w);
        return SUM_W'(w.prev) + SUM_W'(w.next) + (SUM_W'(w.cur) << 1);
    endfunction
endpackage

// File: rtl/gauss_ctrl.sv
module gauss_ctrl
    import gauss_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       last,
    output flt_state_e state,
    output logic       clear,
    output logic       adv,
    output logic       busy
);
    flt_state_e nxt;

    always_comb begin
        nxt   = state;
        clear = 1'b0;
        adv   = 1'b0;
        unique case (state)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    nxt   = ST_HPASS;
                    clear = 1'b1;
                end
            end
            ST_HPASS: begin
                adv = 1'b1;
                if (last) begin
                    nxt   = ST_VPASS;
                    clear = 1'b1;
                end
            end
            ST_VPASS: begin
                adv = 1'b1;
                if (last) nxt = ST_DONE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    assign busy = (state == ST_HPASS) || (state == ST_VPASS);

    // R9: reset lands in idle
    assert_reset_idle_R9: assert property (@(posedge clk)
        rst |=> (state == ST_IDLE));
endmodule

// File: rtl/gauss_addr_gen.sv
module gauss_addr_gen #(
    parameter int IMG_W = 32,
    parameter int IMG_H = 32,
    localparam int NPIX = IMG_W * IMG_H,
    localparam int AW   = $clog2(NPIX),
    localparam int CW   = $clog2(IMG_W),
    localparam int RW   = $clog2(IMG_H)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          adv,
    output logic [AW-1:0] idx,
    output logic [AW-1:0] idx_l,
    output logic [AW-1:0] idx_r,
    output logic [AW-1:0] idx_u,
    output logic [AW-1:0] idx_d,
    output logic          last
);
    localparam logic [CW-1:0] COL_MAX = CW'(IMG_W - 1);
    localparam logic [RW-1:0] ROW_MAX = RW'(IMG_H - 1);
    localparam logic [AW-1:0] STRIDE  = AW'(IMG_W);

    logic [CW-1:0] col;
    logic [RW-1:0] row;

    assign last = (col == COL_MAX) && (row == ROW_MAX);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            col <= '0;
            row <= '0;
            idx <= '0;
        end else if (adv) begin
            if (col == COL_MAX) begin
                col <= '0;
                row <= (row == ROW_MAX) ? '0 : row + RW'(1);
            end else begin
                col <= col + CW'(1);
            end
            idx <= last ? '0 : idx + AW'(1);
        end
    end

    always_comb begin
        idx_l = (col == '0)      ? idx : idx - AW'(1);
        idx_r = (col == COL_MAX) ? idx : idx + AW'(1);
        idx_u = (row == '0)      ? idx : idx - STRIDE;
        idx_d = (row == ROW_MAX) ? idx : idx + STRIDE;
    end

    // R1: linear address tracks row-major position
    assert_rowmajor_R1: assert property (@(posedge clk) disable iff (rst)
        int'(idx) == int'(row) * IMG_W + int'(col));
    // R4: vertical neighbours never leave the frame
    assert_edge_clamp_R4: assert property (@(posedge clk) disable iff (rst)
        (int'(idx_d) < NPIX) && (idx_u <= idx) && (idx_r - idx_l <= AW'(2)));
endmodule

// File: rtl/gauss_tap3.sv
module gauss_tap3
    import gauss_pkg::*;
(
    input  tap_win_t         win,
    output logic [SUM_W-1:0] sum
);
    assign sum = tap121(win);
endmodule

// File: rtl/gauss_sep_filter.sv
module gauss_sep_filter
    import gauss_pkg::*;
#(
    parameter int IMG_W = 32,
    parameter int IMG_H = 32,
    localparam int NPIX = IMG_W * IMG_H,
    localparam int AW   = $clog2(NPIX)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             ld_we,
    input  logic [AW-1:0]    ld_addr,
    input  logic [PIX_W-1:0] ld_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [PIX_W-1:0] rd_data,
    output logic             done
);
    flt_state_e       state;
    logic             clear, adv, busy, last;
    logic [AW-1:0]    idx, idx_l, idx_r, idx_u, idx_d;
    tap_win_t         win;
    logic [SUM_W-1:0] sum;

    logic [PIX_W-1:0] pix_mem [NPIX];
    logic [MID_W-1:0] mid_mem [NPIX];
    logic [PIX_W-1:0] res_mem [NPIX];

    gauss_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .last  (last),
        .state (state),
        .clear (clear),
        .adv   (adv),
        .busy  (busy)
    );

    gauss_addr_gen #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_addr (
        .clk   (clk),
        .rst   (rst),
        .clear (clear),
        .adv   (adv),
        .idx   (idx),
        .idx_l (idx_l),
        .idx_r (idx_r),
        .idx_u (idx_u),
        .idx_d (idx_d),
        .last  (last)
    );

    always_comb begin
        if (state == ST_VPASS) begin
            win.prev = mid_mem[idx_u];
            win.cur  = mid_mem[idx];
            win.next = mid_mem[idx_d];
        end else begin
            win.prev = MID_W'(pix_mem[idx_l]);
            win.cur  = MID_W'(pix_mem[idx]);
            win.next = MID_W'(pix_mem[idx_r]);
        end
    end

    gauss_tap3 u_tap (
        .win (win),
        .sum (sum)
    );

    always_ff @(posedge clk) begin
        if (ld_we && !busy) pix_mem[ld_addr] <= ld_data;
    end

    always_ff @(posedge clk) begin
        if (state == ST_HPASS) mid_mem[idx] <= sum[MID_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (state == ST_VPASS) res_mem[idx] <= sum[SUM_W-1:SHIFT];
    end

    assign rd_data = res_mem[rd_addr];
    assign done    = (state == ST_DONE);

    // R3: column sum never exceeds 16*255, so the shifted value fits 8 bits
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_VPASS) |-> (sum <= SUM_W'(16 * 255)));
    // R2: row sums stored in the buffer fit 0..1020
    assert_mid_range_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HPASS) |-> (sum <= SUM_W'(4 * 255)));
    // R7: a sweep keeps stepping whatever start does
    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && !last) |=> ((state == $past(state)) && (idx == $past(idx) + AW'(1))));
    // R6: done holds until a start
    assert_done_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);
    // R9: reset drops done
    assert_reset_done_R9: assert property (@(posedge clk)
        rst |=> !done);
endmodule

// File: tb/gauss_sep_filter_tb_top.sv
module gauss_sep_filter_tb_top;
    localparam int W  = 16;
    localparam int H  = 8;
    localparam int N  = W * H;
    localparam int AW = $clog2(N);

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          ld_we = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [7:0]    ld_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic          done;

    gauss_sep_filter #(.IMG_W(W), .IMG_H(H)) dut_i (
        .clk(clk), .rst(rst), .start(start), .ld_we(ld_we),
        .ld_addr(ld_addr), .ld_data(ld_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .done(done)
    );

    int total = 0;
    int bad   = 0;
    bit finished = 0;
    int frame [N];
    int seed = 32'h1234_5678;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    function automatic int px(input int r, input int c);
        int rr = (r < 0) ? 0 : (r >= H) ? H - 1 : r;
        int cc = (c < 0) ? 0 : (c >= W) ? W - 1 : c;
        return frame[rr * W + cc];
    endfunction

    function automatic int hval(input int r, input int c);
        return px(r, c - 1) + 2 * px(r, c) + px(r, c + 1);
    endfunction

    function automatic int vval(input int r, input int c);
        int ru = (r == 0) ? 0 : r - 1;
        int rd = (r == H - 1) ? H - 1 : r + 1;
        return (hval(ru, c) + 2 * hval(r, c) + hval(rd, c)) / 16;
    endfunction

    task automatic load_frame();
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            ld_we   = 1'b1;
            ld_addr = AW'(i);
            ld_data = 8'(frame[i]);
        end
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic run(input bit inject, input bit was_done, output int cyc);
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        if (was_done) chk("R6 done cleared by start", int'(done), 0);
        cyc = 0;
        while (!done && cyc < 4 * N) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            start   = inject && (cyc == 5);
            ld_we   = inject && (cyc == 2);
            ld_addr = AW'(N - 1);
            ld_data = 8'(255 - frame[N - 1]);
        end
        start = 1'b0;
        ld_we = 1'b0;
    endtask

    task automatic compare(input string tag);
        for (int r = 0; r < H; r++) begin
            for (int c = 0; c < W; c++) begin
                @(negedge clk);
                rd_addr = AW'(r * W + c);
                #1;
                if (r == 0 || c == 0 || r == H - 1 || c == W - 1)
                    chk({tag, " R4 border pixel"}, int'(rd_data), vval(r, c));
                else
                    chk({tag, " R2_R3_R10 interior pixel"}, int'(rd_data), vval(r, c));
            end
        end
    endtask

    function automatic int rnd();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 16) & 255;
    endfunction

    initial begin
        int cyc;
        bit prev_done;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R9 done low after reset", int'(done), 0);
        prev_done = 0;

        for (int p = 0; p < 5; p++) begin
            for (int i = 0; i < N; i++) begin
                case (p)
                    0: frame[i] = rnd();
                    1: frame[i] = 255;
                    2: frame[i] = 0;
                    3: frame[i] = (i == 3 * W + 5) ? 255 : 0;
                    default: frame[i] = ((i % W) < W / 2) ? 0 : 255;
                endcase
            end
            load_frame();
            run(p == 0, prev_done, cyc);
            chk("R5 completion latency", cyc, 2 * N);
            if (p == 0) begin
                chk("R7 latency with start mid-sweep", cyc, 2 * N);
                compare("R8 load ignored while busy");
                for (int k = 0; k < 20; k++) @(negedge clk);
                chk("R6 done held", int'(done), 1);
            end else if (p == 1) begin
                compare("R3 saturated frame");
                @(negedge clk);
                rd_addr = AW'(2 * W + 7);
                #1;
                chk("R3 uniform 255 stays 255", int'(rd_data), 255);
            end else if (p == 3) begin
                compare("R1 impulse row-major");
                @(negedge clk);
                rd_addr = AW'(3 * W + 5);
                #1;
                chk("R1 impulse centre", int'(rd_data), 63);
            end else begin
                compare("R2 pattern");
            end
            prev_done = 1;
        end

        // reset during a run
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (50) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R9 done cleared by reset", int'(done), 0);
        repeat (3 * N) @(negedge clk);
        chk("R9 idle without start", int'(done), 0);
        run(0, 0, cyc);
        chk("R9 R5 restart latency", cyc, 2 * N);
        compare("R9 restart result");

        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            summary();
            $finish;
        end
    end
endmodule